// File: doc/BRIEF.md
# Multiplexed LCD Drive-Level Sequencer

This block produces, for every common and segment electrode of a three-way multiplexed liquid-crystal panel, a 2-bit code that picks one of four supply rails: VSS, a lower intermediate rail, an upper intermediate rail or VDD. An analog switch bank outside the block turns these codes into pin voltages. The block steps through a fixed frame on an oscillator tick. Each common electrode is selected once with one polarity and once with the other, so every pixel sees no net DC. It supports a one-third bias drive and a one-half bias drive. In half bias the two intermediate rails are tied together outside the block.

The display map, the blanking flag and the bias choice are not sampled on every clock. They are captured into a shadow only on the tick that ends a phase, or continuously while low power is held. For this reason the map needs no handshake: the owner keeps it steady and the block takes whatever is present at the boundary. Low power clears the sequence and drives every electrode to VSS. Blanking turns off every segment and leaves the commons running.

Top module: `lcd_wave_seq`

## Requirements
- R1: While reset is asserted, and after its release until the first clock edge, every output code is 00.
- R2: Code encoding is 00=VSS, 01=lower intermediate, 10=upper intermediate, 11=VDD. In one-third bias the selected common is 00 in positive phases and 11 in negative phases. Unselected commons are 10 in positive phases and 01 in negative phases.
- R3: In one-third bias a lit segment is 11 in positive phases and 00 in negative phases. An unlit segment is 01 in positive phases and 10 in negative phases.
- R4: In half bias an unselected common is 10 in both polarities. A lit segment is 11 positive and 00 negative. An unlit segment is 00 positive and 11 negative. No segment ever takes 01 or 10, and no common takes 01.
- R5: A frame has six phases of 64 oscillator ticks each, 384 ticks in all. The phases run in the order COM1, COM2, COM3 positive, then COM1, COM2, COM3 negative. Exactly one common is selected (00 or 11) at any time outside low power.
- R6: Map bit 3*s+c lights segment s (0..31) while common c (0=COM1..2=COM3) is selected. Segment s drives seg_lvl[2s+1:2s] and common c drives com_lvl[2c+1:2c].
- R7: With blanking set, every segment is driven as unlit and the commons keep their normal waveform.
- R8: Low power drives every output to 00 from the next clock edge and clears the sequence. After release, the first edge outputs phase COM1-positive using the map present during low power.
- R9: Map, blanking and bias changes take effect only at a phase boundary. The values present on the clock edge whose tick ends a phase are the ones used for the next phase.
- R10: While the oscillator tick is low the sequence does not advance.
- R11: Outputs are registered. A new phase appears one clock edge after the edge that advances the phase counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Oscillator enable, one pulse per oscillator cycle |
| low_power | input | 1 | Stop sequence, all outputs VSS |
| blank | input | 1 | Drive all segments as unlit |
| half_bias | input | 1 | 1 = half bias, 0 = one-third bias |
| disp_map | input | 96 | Pixel map, bit 3*s+c |
| com_lvl | output | 6 | Common rail codes, 2 bits per common |
| seg_lvl | output | 64 | Segment rail codes, 2 bits per segment |

## Verification
Two events can land in the same clock: a new display map arriving, and the tick that closes a phase. The bench sets up this coincidence by changing the map in the half cycle just before the phase-ending edge, and again in the half cycle just after it. It then checks that the first change shows up in the very next phase and the second only one phase later. A low-power request raised mid-frame, and a long stall of the oscillator tick, are also judged against the phase that the counted ticks predict.

// File: rtl/lcd_seq_pkg.sv
`timescale 1ns/1ps
package lcd_seq_pkg;

  typedef enum logic [1:0] {
    LV_VSS  = 2'b00,
    LV_MIDL = 2'b01,
    LV_MIDH = 2'b10,
    LV_VDD  = 2'b11
  } rail_e;

  // Common electrode rail for one slot.
  function automatic rail_e com_rail(input logic sel, input logic neg, input logic half);
    rail_e r;
    if (sel)       r = neg ? LV_VDD : LV_VSS;
    else if (half) r = LV_MIDH;
    else           r = neg ? LV_MIDL : LV_MIDH;
    return r;
  endfunction

  // Segment electrode rail for one slot.
  function automatic rail_e seg_rail(input logic lit, input logic neg, input logic half);
    rail_e r;
    if (half)     r = (lit ^ neg) ? LV_VDD : LV_VSS;
    else if (lit) r = neg ? LV_VSS : LV_VDD;
    else          r = neg ? LV_MIDH : LV_MIDL;
    return r;
  endfunction

endpackage

// File: rtl/lcd_phase_timer.sv
`timescale 1ns/1ps
module lcd_phase_timer #(
  parameter int PHASE_LEN = 64,
  parameter int N_PHASE   = 6,
  localparam int PW       = (N_PHASE > 1) ? $clog2(N_PHASE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          halt,
  output logic [PW-1:0] phase,
  output logic          phase_adv
);
  localparam int CW = (PHASE_LEN > 1) ? $clog2(PHASE_LEN) : 1;
  localparam logic [CW-1:0] CYC_LAST = CW'(PHASE_LEN - 1);
  localparam logic [PW-1:0] PH_LAST  = PW'(N_PHASE - 1);

  logic [CW-1:0] cyc;

  assign phase_adv = tick && !halt && (cyc == CYC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc   <= '0;
      phase <= '0;
    end else if (halt) begin
      cyc   <= '0;
      phase <= '0;
    end else if (tick) begin
      if (cyc == CYC_LAST) begin
        cyc   <= '0;
        phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcd_cfg_shadow.sv
`timescale 1ns/1ps
module lcd_cfg_shadow #(
  parameter int W = 98
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/lcd_level_map.sv
`timescale 1ns/1ps
module lcd_level_map
  import lcd_seq_pkg::*;
#(
  parameter int N_COM = 3,
  parameter int N_SEG = 32,
  parameter int PW    = 3
) (
  input  logic [PW-1:0]          phase,
  input  logic [N_COM*N_SEG-1:0] map,
  input  logic                   blank,
  input  logic                   half,
  output logic [2*N_COM-1:0]     com_nxt,
  output logic [2*N_SEG-1:0]     seg_nxt
);
  logic          neg;
  logic [PW-1:0] slot;
  logic [N_COM-1:0] sel_oh;

  always_comb begin
    neg  = (phase >= PW'(N_COM));
    slot = neg ? phase - PW'(N_COM) : phase;
  end

  for (genvar c = 0; c < N_COM; c++) begin : g_com
    assign sel_oh[c] = (slot == PW'(c));
    assign com_nxt[2*c +: 2] = com_rail(sel_oh[c], neg, half);
  end

  for (genvar s = 0; s < N_SEG; s++) begin : g_seg
    logic [N_COM-1:0] grp;
    logic             lit;
    assign grp = map[N_COM*s +: N_COM];
    assign lit = (|(grp & sel_oh)) && !blank;
    assign seg_nxt[2*s +: 2] = seg_rail(lit, neg, half);
  end
endmodule

// File: rtl/lcd_wave_seq.sv
`timescale 1ns/1ps
module lcd_wave_seq #(
  parameter int N_COM     = 3,
  parameter int N_SEG     = 32,
  parameter int PHASE_LEN = 64,
  localparam int N_BITS   = N_COM * N_SEG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              low_power,
  input  logic              blank,
  input  logic              half_bias,
  input  logic [N_BITS-1:0] disp_map,
  output logic [2*N_COM-1:0] com_lvl,
  output logic [2*N_SEG-1:0] seg_lvl
);
  localparam int N_PHASE = 2 * N_COM;
  localparam int PW      = $clog2(N_PHASE);
  localparam int CFG_W   = N_BITS + 2;

  logic [PW-1:0]      phase;
  logic               phase_adv;
  logic [CFG_W-1:0]   cfg_q;
  logic               half_q;
  logic               blank_q;
  logic [N_BITS-1:0]  map_q;
  logic [2*N_COM-1:0] com_nxt;
  logic [2*N_SEG-1:0] seg_nxt;

  lcd_phase_timer #(.PHASE_LEN(PHASE_LEN), .N_PHASE(N_PHASE)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (osc_tick),
    .halt      (low_power),
    .phase     (phase),
    .phase_adv (phase_adv)
  );

  lcd_cfg_shadow #(.W(CFG_W)) u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (phase_adv | low_power),
    .d     ({half_bias, blank, disp_map}),
    .q     (cfg_q)
  );

  assign half_q  = cfg_q[CFG_W-1];
  assign blank_q = cfg_q[CFG_W-2];
  assign map_q   = cfg_q[N_BITS-1:0];

  lcd_level_map #(.N_COM(N_COM), .N_SEG(N_SEG), .PW(PW)) u_levels (
    .phase   (phase),
    .map     (map_q),
    .blank   (blank_q),
    .half    (half_q),
    .com_nxt (com_nxt),
    .seg_nxt (seg_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      com_lvl <= '0;
      seg_lvl <= '0;
    end else if (low_power) begin
      com_lvl <= '0;
      seg_lvl <= '0;
    end else begin
      com_lvl <= com_nxt;
      seg_lvl <= seg_nxt;
    end
  end
endmodule

// File: rtl/lcd_wave_seq_sva.sv
`timescale 1ns/1ps
module lcd_wave_seq_sva #(
  parameter int N_COM = 3,
  parameter int N_SEG = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               low_power,
  input logic               phase_adv,
  input logic               half_q,
  input logic [2*N_COM-1:0] com_lvl,
  input logic [2*N_SEG-1:0] seg_lvl
);
  logic [1:0] warm;
  logic [7:0] sel_cnt;
  logic       seg_mid;
  logic       com_low_mid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           warm <= '0;
    else if (warm != 2'd3) warm <= warm + 1'b1;
  end

  always_comb begin
    sel_cnt     = '0;
    com_low_mid = 1'b0;
    for (int c = 0; c < N_COM; c++) begin
      if (com_lvl[2*c +: 2] == 2'b00 || com_lvl[2*c +: 2] == 2'b11) sel_cnt = sel_cnt + 8'd1;
      if (com_lvl[2*c +: 2] == 2'b01) com_low_mid = 1'b1;
    end
    seg_mid = 1'b0;
    for (int s = 0; s < N_SEG; s++) begin
      if (seg_lvl[2*s +: 2] == 2'b01 || seg_lvl[2*s +: 2] == 2'b10) seg_mid = 1'b1;
    end
  end

  assert_lowpwr_vss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd1 && $past(low_power)) |-> (com_lvl == '0 && seg_lvl == '0));

  assert_one_common_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd1 && !$past(low_power)) |-> (sel_cnt == 8'd1));

  assert_slot_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2 && !$past(phase_adv, 2) && !$past(low_power) && !$past(low_power, 2))
      |-> ($stable(seg_lvl) && $stable(com_lvl)));

  assert_half_two_rails_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd1 && $past(half_q)) |-> (!seg_mid && !com_low_mid));
endmodule

bind lcd_wave_seq lcd_wave_seq_sva #(.N_COM(N_COM), .N_SEG(N_SEG)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .low_power (low_power),
  .phase_adv (phase_adv),
  .half_q    (half_q),
  .com_lvl   (com_lvl),
  .seg_lvl   (seg_lvl)
);

// File: tb/lcd_wave_seq_tb.sv
`timescale 1ns/1ps
module lcd_wave_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_tick = 1'b0;
  logic        low_power = 1'b0;
  logic        blank = 1'b0;
  logic        half_bias = 1'b0;
  logic [95:0] disp_map = '0;
  logic [5:0]  com_lvl;
  logic [63:0] seg_lvl;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lcd_wave_seq u_dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .low_power(low_power),
    .blank(blank), .half_bias(half_bias), .disp_map(disp_map),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  // {half, blank, map}
  localparam logic [97:0] VEC [6] = '{
    {1'b0, 1'b0, 96'h0},
    {1'b0, 1'b0, 96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF},
    {1'b0, 1'b0, 96'h9249_2492_4924_9249_2492_4924},
    {1'b1, 1'b0, 96'h0123_4567_89AB_CDEF_FEDC_BA98},
    {1'b1, 1'b1, 96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF},
    {1'b0, 1'b1, 96'h5555_AAAA_3C3C_C3C3_0F0F_F0F0}
  };

  function automatic logic [5:0] exp_com(int p, bit h);
    logic [5:0] r;
    bit neg = (p >= 3);
    for (int c = 0; c < 3; c++) begin
      if ((p % 3) == c) r[2*c +: 2] = neg ? 2'b11 : 2'b00;
      else if (h)       r[2*c +: 2] = 2'b10;
      else              r[2*c +: 2] = neg ? 2'b01 : 2'b10;
    end
    return r;
  endfunction

  function automatic logic [63:0] exp_seg(int p, bit h, bit b, logic [95:0] m);
    logic [63:0] r;
    bit neg = (p >= 3);
    for (int s = 0; s < 32; s++) begin
      bit lit = m[3*s + (p % 3)] && !b;
      if (h)        r[2*s +: 2] = (lit ^ neg) ? 2'b11 : 2'b00;
      else if (lit) r[2*s +: 2] = neg ? 2'b00 : 2'b11;
      else          r[2*s +: 2] = neg ? 2'b10 : 2'b01;
    end
    return r;
  endfunction

  task automatic chk(string req, logic [5:0] ec, logic [63:0] es);
    n_vec++;
    if (com_lvl !== ec || seg_lvl !== es) begin
      n_bad++;
      $display("FAIL %s: com=%h seg=%h expected com=%h seg=%h", req, com_lvl, seg_lvl, ec, es);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // Loads settings through low power; returns at the negedge before the first active edge.
  task automatic restart(bit h, bit b, logic [95:0] m);
    @(negedge clk);
    half_bias = h; blank = b; disp_map = m; low_power = 1'b1; osc_tick = 1'b1;
    @(negedge clk);
    low_power = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    wait_n(3);
    chk("R1 in reset", 6'h0, 64'h0);
    rst_n = 1'b1;
    #0.1;
    chk("R1 after release", 6'h0, 64'h0);

    // R2/R3/R4/R5/R6/R7 table walk, phase 6 wraps to phase 0 (R5 frame of 384)
    for (int i = 0; i < 6; i++) begin
      bit h = VEC[i][97];
      bit b = VEC[i][96];
      logic [95:0] m = VEC[i][95:0];
      string tag = b ? "R7 blank" : (h ? "R4 half R6" : "R2/R3/R6 third");
      restart(h, b, m);
      wait_n(33);
      for (int p = 0; p <= 6; p++) begin
        if (p > 0) wait_n(64);
        chk($sformatf("%s R5 vec%0d phase%0d", tag, i, p), exp_com(p % 6, h), exp_seg(p % 6, h, b, m));
      end
    end

    // R9/R7: mid-phase changes wait for the boundary
    restart(1'b1, 1'b0, 96'h0);
    wait_n(20);
    disp_map = {96{1'b1}};
    wait_n(20);
    chk("R9 mid-phase map held", exp_com(0, 1), exp_seg(0, 1, 0, 96'h0));
    wait_n(64);
    chk("R9 map at next phase", exp_com(1, 1), exp_seg(1, 1, 0, {96{1'b1}}));
    blank = 1'b1;
    wait_n(10);
    chk("R7 blank held mid-phase", exp_com(1, 1), exp_seg(1, 1, 0, {96{1'b1}}));
    wait_n(64);
    chk("R7 blank at next phase", exp_com(2, 1), exp_seg(2, 1, 1, {96{1'b1}}));
    blank = 1'b0;

    // R9/R11: map change coinciding with the phase-ending edge
    restart(1'b0, 1'b0, 96'h0);
    wait_n(63);
    disp_map = {96{1'b1}};
    wait_n(1);
    chk("R11 boundary edge still old", exp_com(0, 0), exp_seg(0, 0, 0, 96'h0));
    disp_map = 96'h0;
    wait_n(1);
    chk("R9 captured on ending tick", exp_com(1, 0), exp_seg(1, 0, 0, {96{1'b1}}));
    wait_n(64);
    chk("R9 late change next phase", exp_com(2, 0), exp_seg(2, 0, 0, 96'h0));

    // R8: low power mid-frame
    restart(1'b0, 1'b0, {96{1'b1}});
    wait_n(100);
    chk("R8 running before stop", exp_com(1, 0), exp_seg(1, 0, 0, {96{1'b1}}));
    low_power = 1'b1;
    wait_n(1);
    chk("R8 outputs VSS", 6'h0, 64'h0);
    wait_n(50);
    chk("R8 outputs stay VSS", 6'h0, 64'h0);
    low_power = 1'b0;
    wait_n(1);
    chk("R8 restart at phase 0", exp_com(0, 0), exp_seg(0, 0, 0, {96{1'b1}}));

    // R10: oscillator stall freezes the sequence
    restart(1'b0, 1'b0, 96'h0);
    wait_n(11);
    osc_tick = 1'b0;
    wait_n(200);
    chk("R10 stalled phase held", exp_com(0, 0), exp_seg(0, 0, 0, 96'h0));
    osc_tick = 1'b1;
    wait_n(40);
    chk("R10 resumed same phase", exp_com(0, 0), exp_seg(0, 0, 0, 96'h0));
    wait_n(20);
    chk("R10 advance after 64 ticks", exp_com(1, 0), exp_seg(1, 0, 0, 96'h0));

    done = 1;
    finish_run();
  end
endmodule